// File: doc/BRIEF.md
# Register Window Controller

This block keeps the bookkeeping state of a windowed integer register file. That state is the current window pointer, the count of windows free for a push, the count of windows that can be popped, the count of clean windows, the count of windows owned by another context, and a trap-selection register made of two 3-bit fields. Each cycle it accepts at most one command. A command is a window push, a window pop, a privileged read of one state register, or a privileged write of one state register.

For a push or pop, the block decides whether the instruction completes. If it does not, the block reports which trap it raises: spill, fill or clean-window. It then writes back the updated counters and always moves the window pointer. A completed push or pop raises a result-write enable, so that the surrounding pipeline can write its result into the new window. The register file itself and trap vectoring are handled elsewhere.

All counters and the pointer are `$clog2(NWIN)` bits wide and wrap modulo `NWIN`. The operand ports are as wide as the widest state register. Every output except the pointer is registered and shows the result of a command in the cycle after that command is sampled.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the free-push count is NWIN-2, the poppable count is 0, the clean count is NWIN-1, the other-context count is 0, the trap-selection register is 0, and trap_valid_o, res_we_o and rd_data_o are 0.
- R2: A push (cmd_op_i=1) with a free-push count of 0 raises a spill trap and advances the pointer by 2 modulo NWIN. It leaves the counters unchanged and gives no result write.
- R3: A push with a nonzero free-push count and a clean count equal to the poppable count raises a clean-window trap and advances the pointer by 1. It leaves the counters unchanged.
- R4: Any other push advances the pointer by 1, decrements the free-push count, increments the poppable count and pulses res_we_o with no trap.
- R5: A pop (cmd_op_i=2) always moves the pointer back by 1 modulo NWIN. With a poppable count of 0 it raises a fill trap and changes no counter. Otherwise it increments the free-push count, decrements the poppable count and pulses res_we_o.
- R6: trap_type_o[4:3] encodes the trap kind: 1 for spill, 2 for fill, 3 for clean-window. For spill and fill, trap_type_o[2:0] is bits [5:3] of the trap-selection register when the other-context count is nonzero, and bits [2:0] otherwise. For clean-window, and when there is no trap, those bits are 0.
- R7: A privileged write (cmd_op_i=4) stores opnd_a_i XOR opnd_b_i into the register chosen by pr_sel_i. The selectors are 9 for the pointer, A for free-push, B for poppable, C for clean, D for other-context and E for trap-selection. Counters take the low $clog2(NWIN) bits, and the trap-selection register takes 6 bits.
- R8: A privileged read (cmd_op_i=3) with a valid selector returns the zero-extended register on rd_data_o and pulses res_we_o.
- R9: A selector outside 9..E makes a write change nothing and a read return res_we_o=0 and rd_data_o=0. The op codes 0 and 5..7 have no effect.
- R10: trap_valid_o, trap_type_o, res_we_o and rd_data_o appear in the cycle after the command and last one cycle. trap_valid_o and res_we_o are never high together.
- R11: When a push finds both the spill condition and the clean-window condition, the spill wins.
- R12: The pointer wraps: a push from NWIN-1 gives 0, and a pop from 0 gives NWIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_op_i | input | 3 | 1 push, 2 pop, 3 privileged read, 4 privileged write |
| pr_sel_i | input | 4 | Privileged register selector (9..E) |
| opnd_a_i | input | DW (6) | First operand of a privileged write |
| opnd_b_i | input | DW (6) | Second operand of a privileged write |
| cwp_o | output | IW (3) | Current window pointer |
| trap_valid_o | output | 1 | A push or pop raised a trap |
| trap_type_o | output | 5 | Trap kind and selected trap-selection field |
| res_we_o | output | 1 | The result may be written to the register file |
| rd_data_o | output | DW (6) | Privileged read data |

## Verification
Within one push, the spill test and the clean-window test can both be true. The free-push count is 0 and, at the same time, the clean count equals the poppable count. The bench provokes this by writing the clean count to match the poppable count while the free-push count is already exhausted. It then expects a spill with a pointer step of 2 and no clean-window report. Immediately after, it writes a free-push count of 1, so that only the clean-window condition holds, and checks that the same push shape now takes the clean-window path.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int WSF_W = 3;
   localparam int WST_W = 2 * WSF_W;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_PUSH = 3'd1,
      OP_POP  = 3'd2,
      OP_PRD  = 3'd3,
      OP_PWR  = 3'd4
   } win_op_e;

   typedef enum logic [1:0] {
      TK_NONE  = 2'd0,
      TK_SPILL = 2'd1,
      TK_FILL  = 2'd2,
      TK_CLEAN = 2'd3
   } trap_kind_e;

   localparam logic [3:0] SEL_CWP = 4'h9;
   localparam logic [3:0] SEL_CSV = 4'hA;
   localparam logic [3:0] SEL_CRS = 4'hB;
   localparam logic [3:0] SEL_CLN = 4'hC;
   localparam logic [3:0] SEL_OTH = 4'hD;
   localparam logic [3:0] SEL_WST = 4'hE;

endpackage

// File: rtl/regwin_modstep.sv
// Modular step of a window-sized value by 0..3, up or down.
module regwin_modstep #(
   parameter  int NWIN = 8,
   localparam int IW   = $clog2(NWIN)
) (
   input  logic [IW-1:0] base_i,
   input  logic [1:0]    amt_i,
   input  logic          down_i,
   output logic [IW-1:0] res_o
);

   localparam bit POW2 = (NWIN == (1 << IW));

   generate
      if (POW2) begin : g_pow2
         // natural wrap of the IW-bit adder
         always_comb res_o = down_i ? (base_i - IW'(amt_i)) : (base_i + IW'(amt_i));
      end else begin : g_mod
         logic [IW:0] up_s;
         logic [IW:0] dn_s;
         always_comb begin
            up_s = {1'b0, base_i} + (IW+1)'(amt_i);
            if (up_s >= (IW+1)'(NWIN)) up_s = up_s - (IW+1)'(NWIN);
            if ({1'b0, base_i} >= (IW+1)'(amt_i))
               dn_s = {1'b0, base_i} - (IW+1)'(amt_i);
            else
               dn_s = {1'b0, base_i} + (IW+1)'(NWIN) - (IW+1)'(amt_i);
            res_o = down_i ? dn_s[IW-1:0] : up_s[IW-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/regwin_decide.sv
// Combinational push/pop resolution: trap selection and next counters.
module regwin_decide
   import regwin_pkg::*;
#(
   parameter  int NWIN = 8,
   localparam int IW   = $clog2(NWIN)
) (
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [IW-1:0]    cwp_i,
   input  logic [IW-1:0]    csv_i,
   input  logic [IW-1:0]    crs_i,
   input  logic [IW-1:0]    cln_i,
   input  logic [IW-1:0]    oth_i,
   input  logic [WST_W-1:0] wst_i,
   output logic [IW-1:0]    cwp_nxt_o,
   output logic [IW-1:0]    csv_nxt_o,
   output logic [IW-1:0]    crs_nxt_o,
   output logic             cwp_we_o,
   output logic             cnt_we_o,
   output trap_kind_e       kind_o,
   output logic [WSF_W-1:0] fld_o,
   output logic             grant_o
);

   logic [IW-1:0] cwp_up1, cwp_up2, cwp_dn1;
   logic [IW-1:0] csv_dn1, csv_up1, crs_up1, crs_dn1;
   logic [WSF_W-1:0] sel_fld;

   regwin_modstep #(.NWIN(NWIN)) u_cwp_up1 (.base_i(cwp_i), .amt_i(2'd1), .down_i(1'b0), .res_o(cwp_up1));
   regwin_modstep #(.NWIN(NWIN)) u_cwp_up2 (.base_i(cwp_i), .amt_i(2'd2), .down_i(1'b0), .res_o(cwp_up2));
   regwin_modstep #(.NWIN(NWIN)) u_cwp_dn1 (.base_i(cwp_i), .amt_i(2'd1), .down_i(1'b1), .res_o(cwp_dn1));
   regwin_modstep #(.NWIN(NWIN)) u_csv_dn1 (.base_i(csv_i), .amt_i(2'd1), .down_i(1'b1), .res_o(csv_dn1));
   regwin_modstep #(.NWIN(NWIN)) u_csv_up1 (.base_i(csv_i), .amt_i(2'd1), .down_i(1'b0), .res_o(csv_up1));
   regwin_modstep #(.NWIN(NWIN)) u_crs_up1 (.base_i(crs_i), .amt_i(2'd1), .down_i(1'b0), .res_o(crs_up1));
   regwin_modstep #(.NWIN(NWIN)) u_crs_dn1 (.base_i(crs_i), .amt_i(2'd1), .down_i(1'b1), .res_o(crs_dn1));

   // other-context windows present -> use the upper field
   assign sel_fld = (oth_i != '0) ? wst_i[WST_W-1:WSF_W] : wst_i[WSF_W-1:0];

   always_comb begin
      cwp_nxt_o = cwp_i;
      csv_nxt_o = csv_i;
      crs_nxt_o = crs_i;
      cwp_we_o  = 1'b0;
      cnt_we_o  = 1'b0;
      kind_o    = TK_NONE;
      fld_o     = '0;
      grant_o   = 1'b0;
      if (push_i) begin
         cwp_we_o = 1'b1;
         if (csv_i == '0) begin
            kind_o    = TK_SPILL;
            fld_o     = sel_fld;
            cwp_nxt_o = cwp_up2;
         end else if (cln_i == crs_i) begin
            kind_o    = TK_CLEAN;
            cwp_nxt_o = cwp_up1;
         end else begin
            cwp_nxt_o = cwp_up1;
            csv_nxt_o = csv_dn1;
            crs_nxt_o = crs_up1;
            cnt_we_o  = 1'b1;
            grant_o   = 1'b1;
         end
      end else if (pop_i) begin
         cwp_we_o  = 1'b1;
         cwp_nxt_o = cwp_dn1;
         if (crs_i == '0) begin
            kind_o = TK_FILL;
            fld_o  = sel_fld;
         end else begin
            csv_nxt_o = csv_up1;
            crs_nxt_o = crs_dn1;
            cnt_we_o  = 1'b1;
            grant_o   = 1'b1;
         end
      end
   end

endmodule

// File: rtl/regwin_state.sv
// Window state registers with privileged read/write access.
module regwin_state
   import regwin_pkg::*;
#(
   parameter  int NWIN = 8,
   localparam int IW   = $clog2(NWIN),
   localparam int DW   = (IW > WST_W) ? IW : WST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cwp_we_i,
   input  logic             cnt_we_i,
   input  logic [IW-1:0]    cwp_nxt_i,
   input  logic [IW-1:0]    csv_nxt_i,
   input  logic [IW-1:0]    crs_nxt_i,
   input  logic             pr_we_i,
   input  logic [3:0]       pr_sel_i,
   input  logic [DW-1:0]    pr_wdata_i,
   output logic [IW-1:0]    cwp_o,
   output logic [IW-1:0]    csv_o,
   output logic [IW-1:0]    crs_o,
   output logic [IW-1:0]    cln_o,
   output logic [IW-1:0]    oth_o,
   output logic [WST_W-1:0] wst_o,
   output logic [DW-1:0]    pr_rdata_o,
   output logic             pr_hit_o
);

   localparam bit POW2 = (NWIN == (1 << IW));

   logic [IW-1:0] wr_cnt;

   generate
      if (POW2) begin : g_fold_pow2
         assign wr_cnt = pr_wdata_i[IW-1:0];
      end else begin : g_fold_mod
         assign wr_cnt = (pr_wdata_i[IW-1:0] >= IW'(NWIN)) ?
                         (pr_wdata_i[IW-1:0] - IW'(NWIN)) : pr_wdata_i[IW-1:0];
      end
   endgenerate

   assign pr_hit_o = (pr_sel_i >= SEL_CWP) && (pr_sel_i <= SEL_WST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_o <= '0;
         csv_o <= IW'(NWIN - 2);
         crs_o <= '0;
         cln_o <= IW'(NWIN - 1);
         oth_o <= '0;
         wst_o <= '0;
      end else if (pr_we_i && pr_hit_o) begin
         case (pr_sel_i)
            SEL_CWP: cwp_o <= wr_cnt;
            SEL_CSV: csv_o <= wr_cnt;
            SEL_CRS: crs_o <= wr_cnt;
            SEL_CLN: cln_o <= wr_cnt;
            SEL_OTH: oth_o <= wr_cnt;
            default: wst_o <= pr_wdata_i[WST_W-1:0];
         endcase
      end else begin
         if (cwp_we_i) cwp_o <= cwp_nxt_i;
         if (cnt_we_i) begin
            csv_o <= csv_nxt_i;
            crs_o <= crs_nxt_i;
         end
      end
   end

   always_comb begin
      case (pr_sel_i)
         SEL_CWP: pr_rdata_o = DW'(cwp_o);
         SEL_CSV: pr_rdata_o = DW'(csv_o);
         SEL_CRS: pr_rdata_o = DW'(crs_o);
         SEL_CLN: pr_rdata_o = DW'(cln_o);
         SEL_OTH: pr_rdata_o = DW'(oth_o);
         SEL_WST: pr_rdata_o = DW'(wst_o);
         default: pr_rdata_o = '0;
      endcase
   end

   // pointer never leaves the window range
   p_cwp_in_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp_o) < NWIN);

   // a write with an unknown selector leaves every register alone
   p_bad_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pr_we_i && !pr_hit_o) |=> ($stable(cwp_o) && $stable(csv_o) && $stable(crs_o)
                                  && $stable(cln_o) && $stable(oth_o) && $stable(wst_o)));

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter  int NWIN = 8,
   localparam int IW   = $clog2(NWIN),
   localparam int DW   = (IW > WST_W) ? IW : WST_W,
   localparam int TTW  = 2 + WSF_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid_i,
   input  logic [2:0]     cmd_op_i,
   input  logic [3:0]     pr_sel_i,
   input  logic [DW-1:0]  opnd_a_i,
   input  logic [DW-1:0]  opnd_b_i,
   output logic [IW-1:0]  cwp_o,
   output logic           trap_valid_o,
   output logic [TTW-1:0] trap_type_o,
   output logic           res_we_o,
   output logic [DW-1:0]  rd_data_o
);

   generate
      if (NWIN < 3) begin : g_bad_nwin
         $error("regwin_ctrl: NWIN must be at least 3");
      end
   endgenerate

   logic is_push, is_pop, is_rd, is_wr;
   logic [IW-1:0] csv, crs, cln, oth;
   logic [WST_W-1:0] wst;
   logic [IW-1:0] cwp_nxt, csv_nxt, crs_nxt;
   logic cwp_we, cnt_we, grant, pr_hit;
   trap_kind_e kind;
   logic [WSF_W-1:0] fld;
   logic [DW-1:0] pr_rdata;

   assign is_push = cmd_valid_i && (cmd_op_i == OP_PUSH);
   assign is_pop  = cmd_valid_i && (cmd_op_i == OP_POP);
   assign is_rd   = cmd_valid_i && (cmd_op_i == OP_PRD);
   assign is_wr   = cmd_valid_i && (cmd_op_i == OP_PWR);

   regwin_decide #(.NWIN(NWIN)) u_decide (
      .push_i    (is_push),
      .pop_i     (is_pop),
      .cwp_i     (cwp_o),
      .csv_i     (csv),
      .crs_i     (crs),
      .cln_i     (cln),
      .oth_i     (oth),
      .wst_i     (wst),
      .cwp_nxt_o (cwp_nxt),
      .csv_nxt_o (csv_nxt),
      .crs_nxt_o (crs_nxt),
      .cwp_we_o  (cwp_we),
      .cnt_we_o  (cnt_we),
      .kind_o    (kind),
      .fld_o     (fld),
      .grant_o   (grant)
   );

   regwin_state #(.NWIN(NWIN)) u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .cwp_we_i   (cwp_we),
      .cnt_we_i   (cnt_we),
      .cwp_nxt_i  (cwp_nxt),
      .csv_nxt_i  (csv_nxt),
      .crs_nxt_i  (crs_nxt),
      .pr_we_i    (is_wr),
      .pr_sel_i   (pr_sel_i),
      .pr_wdata_i (opnd_a_i ^ opnd_b_i),
      .cwp_o      (cwp_o),
      .csv_o      (csv),
      .crs_o      (crs),
      .cln_o      (cln),
      .oth_o      (oth),
      .wst_o      (wst),
      .pr_rdata_o (pr_rdata),
      .pr_hit_o   (pr_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trap_valid_o <= 1'b0;
         trap_type_o  <= '0;
         res_we_o     <= 1'b0;
         rd_data_o    <= '0;
      end else begin
         trap_valid_o <= (kind != TK_NONE);
         trap_type_o  <= {kind, fld};
         res_we_o     <= grant || (is_rd && pr_hit);
         rd_data_o    <= (is_rd && pr_hit) ? pr_rdata : '0;
      end
   end

   // a command either traps or completes, never both
   p_trap_excl_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_valid_o && res_we_o));

   p_spill_step2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && csv == '0) |=> (trap_valid_o && trap_type_o[TTW-1:WSF_W] == 2'd1
                                  && int'(cwp_o) == (int'($past(cwp_o)) + 2) % NWIN));

   p_push_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_push && csv != '0 && cln != crs) |=> (res_we_o
                                  && int'(cwp_o) == (int'($past(cwp_o)) + 1) % NWIN));

   p_pop_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pop |=> (int'(cwp_o) == (int'($past(cwp_o)) + NWIN - 1) % NWIN));

   p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_pop && crs == '0) |=> (trap_valid_o && trap_type_o[TTW-1:WSF_W] == 2'd2));

   p_bad_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !pr_hit) |=> (!res_we_o && rd_data_o == '0));

endmodule

// File: tb/regwin_ctrl_tb.sv
`timescale 1ns/1ps
module regwin_ctrl_tb_top;

   localparam int N  = 8;
   localparam int IW = 3;
   localparam int DW = 6;

   typedef struct packed {
      logic [IW-1:0] cwp;
      logic          tv;
      logic [4:0]    tt;
      logic          we;
      logic [DW-1:0] rd;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [3:0] pr_sel = 4'd0;
   logic [DW-1:0] opa = '0, opb = '0;
   logic [IW-1:0] cwp;
   logic tv, we;
   logic [4:0] tt;
   logic [DW-1:0] rd;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   exp_t exp_q[$];
   string tag_q[$];

   // bench model of the window state
   int m_cwp = 0, m_csv = N - 2, m_crs = 0, m_cln = N - 1, m_oth = 0, m_wst = 0;

   always #2 clk = ~clk;

   regwin_ctrl #(.NWIN(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
      .pr_sel_i(pr_sel), .opnd_a_i(opa), .opnd_b_i(opb), .cwp_o(cwp),
      .trap_valid_o(tv), .trap_type_o(tt), .res_we_o(we), .rd_data_o(rd)
   );

   task automatic check(input string tag, input exp_t act, input exp_t exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual cwp=%0d tv=%0d tt=%h we=%0d rd=%h expected cwp=%0d tv=%0d tt=%h we=%0d rd=%h",
                  tag, act.cwp, act.tv, act.tt, act.we, act.rd,
                  exp.cwp, exp.tv, exp.tt, exp.we, exp.rd);
      end
   endtask

   // driver: compute expectation from the requirements and queue it
   task automatic issue(input logic [2:0] op, input logic [3:0] sel,
                        input logic [DW-1:0] a, input logic [DW-1:0] b, input string tag);
      exp_t e;
      int fld, v;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; pr_sel = sel; opa = a; opb = b;
      e = '0;
      fld = (m_oth != 0) ? ((m_wst >> 3) & 7) : (m_wst & 7);
      case (op)
         3'd1: begin
            if (m_csv == 0) begin
               e.tv = 1'b1; e.tt = {2'b01, 3'(fld)}; m_cwp = (m_cwp + 2) % N;
            end else if (m_cln == m_crs) begin
               e.tv = 1'b1; e.tt = 5'b11000; m_cwp = (m_cwp + 1) % N;
            end else begin
               e.we = 1'b1; m_cwp = (m_cwp + 1) % N;
               m_csv = (m_csv + N - 1) % N; m_crs = (m_crs + 1) % N;
            end
         end
         3'd2: begin
            m_cwp = (m_cwp + N - 1) % N;
            if (m_crs == 0) begin
               e.tv = 1'b1; e.tt = {2'b10, 3'(fld)};
            end else begin
               e.we = 1'b1; m_csv = (m_csv + 1) % N; m_crs = (m_crs + N - 1) % N;
            end
         end
         3'd3: begin
            e.we = 1'b1;
            case (sel)
               4'h9: e.rd = DW'(m_cwp);
               4'hA: e.rd = DW'(m_csv);
               4'hB: e.rd = DW'(m_crs);
               4'hC: e.rd = DW'(m_cln);
               4'hD: e.rd = DW'(m_oth);
               4'hE: e.rd = DW'(m_wst);
               default: e.we = 1'b0;
            endcase
         end
         3'd4: begin
            v = int'(a ^ b);
            case (sel)
               4'h9: m_cwp = (v & (2**IW - 1)) % N;
               4'hA: m_csv = (v & (2**IW - 1)) % N;
               4'hB: m_crs = (v & (2**IW - 1)) % N;
               4'hC: m_cln = (v & (2**IW - 1)) % N;
               4'hD: m_oth = (v & (2**IW - 1)) % N;
               4'hE: m_wst = v & 63;
               default: ;
            endcase
         end
         default: ;
      endcase
      e.cwp = IW'(m_cwp);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmd_valid = 1'b0; cmd_op = 3'd0;
      end
   endtask

   // monitor: sample just after each edge, compare against the queue
   initial begin
      exp_t act, e;
      string tag;
      wait (rst_n === 1'b1);
      forever begin
         @(posedge clk);
         #1;
         act = '{cwp: cwp, tv: tv, tt: tt, we: we, rd: rd};
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            tag = tag_q.pop_front();
            check(tag, act, e);
         end else begin
            // R10: outputs are single-cycle pulses, quiet when idle
            e = '0; e.cwp = IW'(m_cwp);
            check("R10 idle", act, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      exp_t e0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      // R1: reset values at the ports
      e0 = '0;
      check("R1 reset outputs", '{cwp: cwp, tv: tv, tt: tt, we: we, rd: rd}, e0);
      rst_n = 1'b1;
      for (int s = 9; s <= 14; s++) issue(3'd3, 4'(s), '0, '0, "R1 reset register");
      idle(2);
      // R7: trap-selection write, other=2 normal=3
      issue(3'd4, 4'hE, 6'h10, 6'h03, "R7 write wstate");
      issue(3'd3, 4'hE, '0, '0, "R8 read wstate");
      // R4: six successful pushes
      for (int k = 0; k < 6; k++) issue(3'd1, 4'h0, '0, '0, "R4 push");
      // R2: free count exhausted -> spill, normal field
      issue(3'd1, 4'h0, '0, '0, "R2 spill normal");
      issue(3'd3, 4'hA, '0, '0, "R2 free count unchanged");
      issue(3'd3, 4'hB, '0, '0, "R2 poppable unchanged");
      // R6: other-context nonzero selects upper field
      issue(3'd4, 4'hD, 6'h02, 6'h00, "R7 write other");
      issue(3'd1, 4'h0, '0, '0, "R6 spill other field");
      // R11: spill and clean conditions together
      issue(3'd4, 4'hC, 6'h06, 6'h00, "R7 write clean");
      issue(3'd1, 4'h0, '0, '0, "R11 spill over clean");
      // R3: clean-window only
      issue(3'd4, 4'hA, 6'h01, 6'h00, "R7 write free");
      issue(3'd1, 4'h0, '0, '0, "R3 clean trap");
      issue(3'd3, 4'hA, '0, '0, "R3 free unchanged");
      issue(3'd3, 4'hB, '0, '0, "R3 poppable unchanged");
      // R5: pops
      issue(3'd2, 4'h0, '0, '0, "R5 pop ok");
      issue(3'd2, 4'h0, '0, '0, "R5 pop ok");
      issue(3'd4, 4'hB, 6'h00, 6'h00, "R7 write poppable");
      issue(3'd2, 4'h0, '0, '0, "R5 fill other field");
      issue(3'd3, 4'hA, '0, '0, "R5 free unchanged after fill");
      issue(3'd4, 4'hD, 6'h00, 6'h00, "R7 clear other");
      issue(3'd2, 4'h0, '0, '0, "R6 fill normal field");
      idle(1);
      // R9: bad selectors and unused ops
      issue(3'd4, 4'hF, 6'h07, 6'h00, "R9 bad write");
      issue(3'd3, 4'hF, '0, '0, "R9 bad read");
      issue(3'd3, 4'h3, '0, '0, "R9 bad read low");
      issue(3'd5, 4'h9, 6'h3F, 6'h00, "R9 unused op");
      issue(3'd0, 4'h9, 6'h3F, 6'h00, "R9 idle op");
      for (int s = 9; s <= 14; s++) issue(3'd3, 4'(s), '0, '0, "R9 state intact");
      // R7: truncation of wide write value
      issue(3'd4, 4'h9, 6'h3D, 6'h30, "R7 write pointer");
      issue(3'd3, 4'h9, '0, '0, "R7 pointer truncated");
      // R12: wrap both ways
      issue(3'd4, 4'h9, 6'h00, 6'h00, "R7 pointer zero");
      issue(3'd4, 4'hB, 6'h03, 6'h00, "R7 poppable three");
      issue(3'd2, 4'h0, '0, '0, "R12 pop wraps to top");
      issue(3'd4, 4'hA, 6'h02, 6'h00, "R7 free two");
      issue(3'd4, 4'hC, 6'h07, 6'h00, "R7 clean seven");
      issue(3'd1, 4'h0, '0, '0, "R12 push wraps to zero");
      idle(4);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule